// File: doc/BRIEF.md
# Debug Log Ring Drain Engine

A target program writes debug text into a ring buffer held inside a 64 KiB window of external memory. It announces new text by advancing a produced pointer. This block keeps its own consumed pointer and compares the two. Whenever they differ and the block is allowed to issue, it works out one contiguous stretch of unread bytes. It then hands the length and absolute byte address of that stretch to a host transfer engine over a valid/ready request channel.

Only one chunk is ever in flight. After a request is accepted, the block waits for a completion pulse from the transfer engine before it issues another. When the produced pointer has wrapped below the consumed pointer, the remaining text is sent as two requests. The first runs to the end of the data area and returns the consumed pointer to zero. The second covers the start of the buffer. The data area begins after a 32-byte header at the bottom of the window.

Firmware reaches the enable bit, the window base and both pointers through a small word-addressed register port. A target soft-reset event clears both pointers.

Top module: `dbgring_drain`

## Requirements
- R1: After reset, the following hold: enable is 0, the window base reads 0x3FF_0000, both pointers read 0, the request output is low and the issue-ready flag is set.
- R2: No request is raised while enable is 0, or while the produced pointer equals the consumed pointer.
- R3: When produced ≥ consumed and they differ, the request carries length = produced − consumed and address = base + 32 + consumed. On acceptance, the consumed pointer becomes the produced pointer.
- R4: When produced < consumed, the request carries length = (2^PTR_W − 32) − consumed and address = base + 32 + consumed. On acceptance, the consumed pointer becomes 0.
- R5: After a request is accepted, no further request is raised until a completion pulse (or R7) sets the issue-ready flag again.
- R6: While the request is valid and not accepted, length and address stay stable and the consumed pointer does not move.
- R7: A control write with bit 7 = 1 sets enable and also sets the issue-ready flag.
- R8: A soft-reset pulse clears both pointers to 0. It takes priority over any pointer write in the same cycle.
- R9: The register map is as follows. Word 0 is control, with enable in bit 7, written when byte enable 0 is set. Word 1 is the base offset in bits [25:0], written only when all four byte enables are set. Word 2 holds {consumed in [31:16], produced in [15:0]}. A write with byte enables [3:2] both set loads consumed, and a write with byte enables [1:0] both set loads produced.
- R10: A target pointer write (tgt_we) loads the produced pointer, and it wins over a firmware write to the produced pointer in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| soft_rst | input | 1 | Target soft-reset event, clears pointers |
| tgt_we | input | 1 | Target produced-pointer write strobe |
| tgt_ptr | input | PTR_W | New produced pointer value |
| reg_we | input | 1 | Firmware register write strobe |
| reg_addr | input | 2 | Register word index |
| reg_be | input | 4 | Byte enables for the write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| req_valid | output | 1 | Chunk request valid |
| req_ready | input | 1 | Transfer engine accepts the request |
| req_len | output | 32 | Chunk length in bytes |
| req_addr | output | 32 | Chunk absolute byte address |
| xfer_done | input | 1 | Completion pulse from transfer engine |

## Verification
The bench sweeps consumed/produced pairs over a reduced 8-bit-pointer configuration, including 0 and the last data-area index. It computes every length, address and next consumed value arithmetically. A design that confused the wrap test would send a huge or negative length. A design that forgot the 32-byte header would send addresses 32 bytes low. A design that advanced the consumed pointer at issue rather than at acceptance would show it moving while the request is held off. After a wrap-around acceptance, the bench checks that the second half is withheld until a completion pulse or an enable write arrives, which catches a design that drops the one-in-flight rule. Soft reset is also driven in the same cycle as a target pointer write, to expose a wrong priority.

// File: rtl/dbgring_pkg.sv
package dbgring_pkg;

    localparam int HDR_BYTES = 32;

    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_BASE = 2'd1,
        REG_PTRS = 2'd2,
        REG_NONE = 2'd3
    } reg_idx_e;

    localparam int CTRL_EN_BIT = 7;

    typedef struct packed {
        logic        pending;
        logic [31:0] len;
        logic [31:0] addr;
        logic [31:0] next_ptr;
    } chunk_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_REQ  = 1'b1
    } issue_st_e;

    function automatic chunk_t plan_chunk(input logic [31:0] prod,
                                          input logic [31:0] cons,
                                          input logic [31:0] base,
                                          input logic [31:0] data_bytes);
        chunk_t c;
        logic   wrapped;
        wrapped    = prod < cons;
        c.pending  = prod != cons;
        c.len      = wrapped ? (data_bytes - cons) : (prod - cons);
        c.addr     = base + 32'(HDR_BYTES) + cons;
        c.next_ptr = wrapped ? 32'd0 : prod;
        return c;
    endfunction

endpackage

// File: rtl/dbgring_regs.sv
module dbgring_regs
    import dbgring_pkg::*;
#(
    parameter int          PTR_W    = 16,
    parameter int          OFS_W    = 26,
    parameter logic [25:0] BASE_RST = 26'h3FF_0000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             soft_rst,
    input  logic             tgt_we,
    input  logic [PTR_W-1:0] tgt_ptr,
    input  logic             reg_we,
    input  logic [1:0]       reg_addr,
    input  logic [3:0]       reg_be,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    input  logic             adv_en,
    input  logic [PTR_W-1:0] adv_ptr,
    output logic             enable,
    output logic             en_set,
    output logic [OFS_W-1:0] base,
    output logic [PTR_W-1:0] prod,
    output logic [PTR_W-1:0] cons
);
    logic wr_ctrl, wr_base, wr_cons, wr_prod;
    logic [15:0] cons16, prod16;

    always_comb begin
        wr_ctrl = reg_we && reg_addr == REG_CTRL && reg_be[0];
        wr_base = reg_we && reg_addr == REG_BASE && (&reg_be);
        wr_cons = reg_we && reg_addr == REG_PTRS && (&reg_be[3:2]);
        wr_prod = reg_we && reg_addr == REG_PTRS && (&reg_be[1:0]);
        en_set  = wr_ctrl && reg_wdata[CTRL_EN_BIT];
        cons16  = 16'(cons);
        prod16  = 16'(prod);
        case (reg_addr)
            REG_CTRL: reg_rdata = 32'(enable) << CTRL_EN_BIT;
            REG_BASE: reg_rdata = 32'(base);
            REG_PTRS: reg_rdata = {cons16, prod16};
            default:  reg_rdata = 32'd0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            enable <= 1'b0;
            base   <= OFS_W'(BASE_RST);
            prod   <= '0;
            cons   <= '0;
        end else begin
            if (wr_ctrl) enable <= reg_wdata[CTRL_EN_BIT];
            if (wr_base) base <= reg_wdata[OFS_W-1:0];
            if (soft_rst) begin
                prod <= '0;
                cons <= '0;
            end else begin
                if (tgt_we)       prod <= tgt_ptr;
                else if (wr_prod) prod <= reg_wdata[PTR_W-1:0];
                if (wr_cons)      cons <= reg_wdata[16 +: PTR_W];
                else if (adv_en)  cons <= adv_ptr;
            end
        end
    end

    // R8
    soft_clear_chk: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> (prod == '0 && cons == '0));

    // R10
    tgt_load_chk: assert property (@(posedge clk) disable iff (rst)
        (tgt_we && !soft_rst) |=> prod == $past(tgt_ptr));

endmodule

// File: rtl/dbgring_chunk.sv
module dbgring_chunk
    import dbgring_pkg::*;
#(
    parameter int PTR_W = 16,
    parameter int OFS_W = 26
) (
    input  logic [PTR_W-1:0] prod,
    input  logic [PTR_W-1:0] cons,
    input  logic [OFS_W-1:0] base,
    output chunk_t           chunk
);
    localparam logic [31:0] DATA_BYTES = 32'((1 << PTR_W) - HDR_BYTES);

    always_comb begin
        chunk = plan_chunk(32'(prod), 32'(cons), 32'(base), DATA_BYTES);
    end
endmodule

// File: rtl/dbgring_issuer.sv
module dbgring_issuer
    import dbgring_pkg::*;
#(
    parameter int PTR_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic             en_set,
    input  chunk_t           chunk,
    input  logic             xfer_done,
    input  logic             req_ready,
    output logic             req_valid,
    output logic [31:0]      req_len,
    output logic [31:0]      req_addr,
    output logic             adv_en,
    output logic [PTR_W-1:0] adv_ptr
);
    localparam logic [31:0] MAX_LEN = 32'((1 << PTR_W) - HDR_BYTES);

    issue_st_e state;
    logic      go_flag;
    logic [PTR_W-1:0] next_q;

    always_comb begin
        req_valid = state == ST_REQ;
        adv_en    = req_valid && req_ready;
        adv_ptr   = next_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            go_flag  <= 1'b1;
            req_len  <= '0;
            req_addr <= '0;
            next_q   <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (enable && go_flag && chunk.pending) begin
                        req_len  <= chunk.len;
                        req_addr <= chunk.addr;
                        next_q   <= chunk.next_ptr[PTR_W-1:0];
                        state    <= ST_REQ;
                    end
                end
                default: begin
                    if (req_ready) begin
                        state   <= ST_IDLE;
                        go_flag <= 1'b0;
                    end
                end
            endcase
            if (xfer_done || en_set) go_flag <= 1'b1;
        end
    end

    // R6
    hold_payload_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_len) && $stable(req_addr)));

    // R5
    one_flight_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(req_valid) |-> $past(go_flag));

    // R2
    issue_gate_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(req_valid) |-> ($past(enable) && $past(chunk.pending)));

    // R3
    len_range_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> (req_len != 32'd0 && req_len <= MAX_LEN));

endmodule

// File: rtl/dbgring_drain.sv
module dbgring_drain
    import dbgring_pkg::*;
#(
    parameter int          PTR_W    = 16,
    parameter int          OFS_W    = 26,
    parameter logic [25:0] BASE_RST = 26'h3FF_0000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             soft_rst,
    input  logic             tgt_we,
    input  logic [PTR_W-1:0] tgt_ptr,
    input  logic             reg_we,
    input  logic [1:0]       reg_addr,
    input  logic [3:0]       reg_be,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    output logic             req_valid,
    input  logic             req_ready,
    output logic [31:0]      req_len,
    output logic [31:0]      req_addr,
    input  logic             xfer_done
);
    logic             enable, en_set, adv_en;
    logic [OFS_W-1:0] base;
    logic [PTR_W-1:0] prod, cons, adv_ptr;
    chunk_t           chunk;

    dbgring_regs #(.PTR_W(PTR_W), .OFS_W(OFS_W), .BASE_RST(BASE_RST)) u_regs (
        .clk(clk), .rst(rst), .soft_rst(soft_rst),
        .tgt_we(tgt_we), .tgt_ptr(tgt_ptr),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_be(reg_be),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .adv_en(adv_en), .adv_ptr(adv_ptr),
        .enable(enable), .en_set(en_set), .base(base),
        .prod(prod), .cons(cons)
    );

    dbgring_chunk #(.PTR_W(PTR_W), .OFS_W(OFS_W)) u_chunk (
        .prod(prod), .cons(cons), .base(base), .chunk(chunk)
    );

    dbgring_issuer #(.PTR_W(PTR_W)) u_issuer (
        .clk(clk), .rst(rst), .enable(enable), .en_set(en_set),
        .chunk(chunk), .xfer_done(xfer_done), .req_ready(req_ready),
        .req_valid(req_valid), .req_len(req_len), .req_addr(req_addr),
        .adv_en(adv_en), .adv_ptr(adv_ptr)
    );

    // R4
    wrap_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (adv_en && !soft_rst && !(reg_we && reg_addr == REG_PTRS) && $past(prod) == prod
         && req_len == 32'((1 << PTR_W) - HDR_BYTES) - 32'(cons)) && prod < cons
        |=> cons == '0);

endmodule

// File: tb/dbgring_drain_tb.sv
module dbgring_drain_tb;
    localparam int PW   = 8;
    localparam int DATA = (1 << PW) - 32;
    localparam logic [25:0] BASE0 = 26'h3FF_0000;

    logic clk = 1'b0, rst = 1'b1, soft_rst = 1'b0, tgt_we = 1'b0;
    logic [PW-1:0] tgt_ptr = '0;
    logic reg_we = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [3:0] reg_be = 4'd0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic req_valid, req_ready = 1'b0, xfer_done = 1'b0;
    logic [31:0] req_len, req_addr;

    int nchk = 0, nfail = 0;
    logic [31:0] base_cur = 32'(BASE0);

    always #4 clk = ~clk;

    dbgring_drain #(.PTR_W(PW)) u_dut (
        .clk(clk), .rst(rst), .soft_rst(soft_rst), .tgt_we(tgt_we), .tgt_ptr(tgt_ptr),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_be(reg_be), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .req_valid(req_valid), .req_ready(req_ready),
        .req_len(req_len), .req_addr(req_addr), .xfer_done(xfer_done)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic rwrite(input logic [1:0] a, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_be = be; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0; reg_be = 4'd0;
    endtask

    task automatic rread(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic tgt(input logic [PW-1:0] p);
        @(negedge clk);
        tgt_we = 1'b1; tgt_ptr = p;
        @(negedge clk);
        tgt_we = 1'b0;
    endtask

    task automatic wait_valid(output bit got);
        got = 1'b0;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (req_valid) begin got = 1'b1; break; end
        end
    endtask

    task automatic quiet(input int n, input string tag);
        bit seen = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (req_valid) seen = 1'b1;
        end
        chk(!seen, tag, seen, 0);
    endtask

    task automatic accept;
        req_ready = 1'b1;
        @(negedge clk);
        req_ready = 1'b0;
        chk(!req_valid, "R5 valid drops after accept", req_valid, 0);
    endtask

    task automatic done_pulse;
        @(negedge clk);
        xfer_done = 1'b1;
        @(negedge clk);
        xfer_done = 1'b0;
    endtask

    task automatic run_pair(input int c, input int p);
        bit got;
        logic [31:0] rd, elen, eaddr;
        int enext;
        bit wrap;
        rwrite(2'd0, 4'b0001, 32'h0);
        rwrite(2'd2, 4'b1100, 32'(c) << 16);
        tgt(PW'(p));
        rwrite(2'd0, 4'b0001, 32'h80);
        if (c == p) begin
            quiet(4, "R2 equal pointers no request");
            return;
        end
        wrap  = p < c;
        elen  = wrap ? 32'(DATA - c) : 32'(p - c);
        eaddr = base_cur + 32 + 32'(c);
        enext = wrap ? 0 : p;
        wait_valid(got);
        chk(got, wrap ? "R4 request raised" : "R3 request raised", got, 1);
        chk(req_len == elen, wrap ? "R4 length" : "R3 length", req_len, elen);
        chk(req_addr == eaddr, wrap ? "R4 address" : "R3 address", req_addr, eaddr);
        @(negedge clk); @(negedge clk);
        chk(req_valid && req_len == elen && req_addr == eaddr, "R6 payload held", req_len, elen);
        rread(2'd2, rd);
        chk(rd[31:16] == 16'(c), "R6 consumed unchanged while pending", rd[31:16], c);
        accept();
        rread(2'd2, rd);
        chk(rd[31:16] == 16'(enext), wrap ? "R4 consumed after accept" : "R3 consumed after accept",
            rd[31:16], enext);
        if (wrap && p != 0) begin
            quiet(3, "R5 second half withheld");
            done_pulse();
            wait_valid(got);
            chk(got && req_len == 32'(p), "R4 second half length", req_len, p);
            chk(req_addr == base_cur + 32, "R4 second half address", req_addr, base_cur + 32);
            accept();
        end
        done_pulse();
    endtask

    initial begin
        #(8 * 190000);
        chk(0, "watchdog expired", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        bit got;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        rread(2'd0, rd); chk(rd == 0, "R1 enable after reset", rd, 0);
        rread(2'd1, rd); chk(rd == 32'(BASE0), "R1 base after reset", rd, BASE0);
        rread(2'd2, rd); chk(rd == 0, "R1 pointers after reset", rd, 0);
        chk(!req_valid, "R1 no request after reset", req_valid, 0);

        // R2 disabled: pending data but no request
        tgt(PW'(9));
        quiet(5, "R2 disabled no request");

        // R10 and R9 pointer fields
        rread(2'd2, rd); chk(rd == 32'd9, "R10 target load produced", rd, 9);
        rwrite(2'd2, 4'b0011, 32'd17);
        rread(2'd2, rd); chk(rd == 32'd17, "R9 firmware load produced", rd, 17);
        fork
            rwrite(2'd2, 4'b0011, 32'd30);
            tgt(PW'(44));
        join
        rread(2'd2, rd); chk(rd[15:0] == 16'd44, "R10 target wins over firmware", rd[15:0], 44);
        rwrite(2'd2, 4'b0100, 32'h0005_0000);
        rread(2'd2, rd); chk(rd[31:16] == 16'd0, "R9 partial upper write ignored", rd[31:16], 0);

        // R9 base writes
        rwrite(2'd1, 4'b0111, 32'h0000_1234);
        rread(2'd1, rd); chk(rd == 32'(BASE0), "R9 partial base write ignored", rd, BASE0);
        rwrite(2'd1, 4'b1111, 32'h0001_2000);
        rread(2'd1, rd); chk(rd == 32'h0001_2000, "R9 base write", rd, 32'h0001_2000);
        base_cur = 32'h0001_2000;

        // R8 soft reset
        rwrite(2'd2, 4'b1100, 32'h0007_0000);
        @(negedge clk); soft_rst = 1'b1; @(negedge clk); soft_rst = 1'b0;
        rread(2'd2, rd); chk(rd == 0, "R8 soft reset clears pointers", rd, 0);
        tgt(PW'(12));
        @(negedge clk); soft_rst = 1'b1; tgt_we = 1'b1; tgt_ptr = PW'(50);
        @(negedge clk); soft_rst = 1'b0; tgt_we = 1'b0;
        rread(2'd2, rd); chk(rd == 0, "R8 soft reset beats target write", rd, 0);

        // R7 enable write re-arms the ready flag
        tgt(PW'(10));
        rwrite(2'd0, 4'b0001, 32'h80);
        rread(2'd0, rd); chk(rd == 32'h80, "R9 enable bit 7 readback", rd, 32'h80);
        wait_valid(got);
        chk(got && req_len == 10, "R3 first chunk", req_len, 10);
        accept();
        tgt(PW'(20));
        quiet(4, "R5 no request before completion");
        rwrite(2'd0, 4'b0001, 32'h80);
        wait_valid(got);
        chk(got && req_len == 10 && req_addr == base_cur + 42, "R7 enable re-arms issue",
            req_len, 10);
        accept();
        done_pulse();

        // sweep of pointer pairs
        for (int ci = 0; ci <= 32; ci++) begin
            for (int pi = 0; pi <= 32; pi++) begin
                run_pair(ci == 32 ? DATA - 1 : ci * 7, pi == 32 ? DATA - 1 : pi * 7);
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule